// File: doc/BRIEF.md
# Isochronous Receive Data Block Parser

This block sits behind the packet receiver of one playback stream. It takes the quadlets of each received isochronous data block one at a time and splits them into audio samples and an optional MIDI quadlet. A start-of-block marker travels with the first quadlet of every block. Each quadlet also carries the iso channel tag of the packet it came from.

Within each block the parser first drops a programmable number of leading quadlets. It then hands out one quadlet per audio channel in channel order, starting at channel 0. When MIDI ports are configured, one more quadlet follows and is handed out as MIDI data. Every audio quadlet carries a label flag, which is read from a per-channel mask that may change while the stream runs.

Skip count, channel count, MIDI port count and iso channel are captured when a block starts, so a configuration change never splits a block. Two error pulses report problems with block length. One fires for each quadlet beyond the expected block length. The other fires when a new block starts before the current one is complete.

Top module: `iso_rx_parser`

## Requirements
- R1: After reset, all output valid and error pulses are low.
- R2: With skip count S, the first S accepted quadlets of each block (counting the start-of-block quadlet as position 0) produce no output.
- R3: The quadlets at positions S to S+N-1 (N = audio channel count) appear on `data_o` with `aud_valid_o` high and `chan_o` = position - S. They appear one clock after the input beat and are unchanged.
- R4: If the MIDI port count (0 to 8) is nonzero, the quadlet at position S+N appears with `midi_valid_o` high. If the count is zero, no MIDI quadlet is produced.
- R5: Every accepted quadlet at position S+N+(MIDI?1:0) or later, up to the next start-of-block, is discarded and raises `err_long_o` for one cycle.
- R6: A start-of-block that arrives before the current block is complete raises `err_short_o` for one cycle. The parser restarts, and the marker quadlet is treated as position 0 of the new block.
- R7: Quadlets whose iso tag differs from the stream's channel produce no output and no error, and do not advance the block position.
- R8: When the iso channel setting is all ones, no quadlet is accepted. A start-of-block seen with that setting ends any block in progress without an error.
- R9: `label_o` of an audio quadlet equals bit `chan_o` of `label_en_i` as sampled in the cycle that quadlet was accepted. A mask change mid-block therefore applies from the next quadlet on.
- R10: While `enable_i` is low, nothing is accepted and the parser goes idle. After `enable_i` returns high, quadlets are discarded silently until the next start-of-block.
- R11: Skip count, audio count, MIDI port count and iso channel are captured at an accepted start-of-block. Changes made mid-block take effect at the next block.
- R12: An audio channel count above MAX_CH is treated as MAX_CH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Streaming enable |
| iso_chan_i | input | ISO_W | Stream iso channel; all ones = unused |
| skip_i | input | SKIP_W | Leading quadlets to drop per block |
| aud_cnt_i | input | CNT_W | Audio channel count |
| midi_ports_i | input | 4 | MIDI port count, 0 to 8 |
| label_en_i | input | MAX_CH | Per-channel label enable mask (live) |
| in_valid_i | input | 1 | Input quadlet valid |
| in_sob_i | input | 1 | Input quadlet starts a data block |
| in_iso_i | input | ISO_W | Iso channel tag of the input quadlet |
| in_data_i | input | 32 | Input quadlet |
| aud_valid_o | output | 1 | Audio quadlet on data_o |
| midi_valid_o | output | 1 | MIDI quadlet on data_o |
| chan_o | output | IDX_W | Audio channel index |
| label_o | output | 1 | Label flag of the audio quadlet |
| data_o | output | 32 | Output quadlet |
| err_long_o | output | 1 | Quadlet beyond block length discarded |
| err_short_o | output | 1 | Block cut short by early start-of-block |

## Verification
The bench builds the parser with MAX_CH = 4 and SKIP_W = 2, which makes the channel count input 3 bits wide. With that build it can sweep every skip count from 0 to 3 and every audio count from 0 to 7, including the clamped values above 4. The sweep is crossed with MIDI port counts of 0, 1 and 8, and each block runs two quadlets past its length. The small width also makes a zero-length block reachable. In that case the start-of-block quadlet itself is a surplus quadlet.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;
  typedef enum logic [1:0] {
    SLOT_SKIP  = 2'd0,
    SLOT_AUDIO = 2'd1,
    SLOT_MIDI  = 2'd2,
    SLOT_EXTRA = 2'd3
  } slot_e;
endpackage

// File: rtl/iso_rx_cfg.sv
module iso_rx_cfg #(
  parameter int MAX_CH = 16,
  parameter int SKIP_W = 4,
  parameter int CNT_W  = 5,
  parameter int ISO_W  = 6,
  parameter int POS_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SKIP_W-1:0] skip_i,
  input  logic [CNT_W-1:0]  aud_cnt_i,
  input  logic [3:0]        midi_ports_i,
  input  logic [ISO_W-1:0]  iso_i,
  output logic [SKIP_W-1:0] eff_skip_o,
  output logic [CNT_W-1:0]  eff_naud_o,
  output logic              eff_midi_o,
  output logic [CNT_W-1:0]  naud_q_o,
  output logic              midi_q_o,
  output logic [ISO_W-1:0]  iso_q_o,
  output logic [POS_W-1:0]  len_q_o
);
  logic [CNT_W-1:0]  naud_c;
  logic              midi_c;
  logic [SKIP_W-1:0] skip_q;
  logic [POS_W-1:0]  len_c;

  // R12 clamp
  assign naud_c = (aud_cnt_i > CNT_W'(MAX_CH)) ? CNT_W'(MAX_CH) : aud_cnt_i;
  assign midi_c = |midi_ports_i;
  assign len_c  = POS_W'(skip_i) + POS_W'(naud_c) + POS_W'(midi_c);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      skip_q   <= '0;
      naud_q_o <= '0;
      midi_q_o <= 1'b0;
      iso_q_o  <= '0;
      len_q_o  <= '0;
    end else if (load_i) begin
      skip_q   <= skip_i;
      naud_q_o <= naud_c;
      midi_q_o <= midi_c;
      iso_q_o  <= iso_i;
      len_q_o  <= len_c;
    end
  end

  // the block-start beat is classified with the values being captured
  assign eff_skip_o = load_i ? skip_i : skip_q;
  assign eff_naud_o = load_i ? naud_c : naud_q_o;
  assign eff_midi_o = load_i ? midi_c : midi_q_o;
endmodule

// File: rtl/iso_rx_slot.sv
module iso_rx_slot
  import iso_rx_pkg::*;
#(
  parameter int SKIP_W = 4,
  parameter int CNT_W  = 5,
  parameter int POS_W  = 7,
  parameter int IDX_W  = 4
) (
  input  logic [POS_W-1:0]  pos_i,
  input  logic [SKIP_W-1:0] skip_i,
  input  logic [CNT_W-1:0]  naud_i,
  input  logic              midi_i,
  output slot_e             kind_o,
  output logic [IDX_W-1:0]  chan_o
);
  logic [POS_W-1:0] aud_end;
  logic [POS_W-1:0] rel;

  assign aud_end = POS_W'(skip_i) + POS_W'(naud_i);
  assign rel     = pos_i - POS_W'(skip_i);
  assign chan_o  = rel[IDX_W-1:0];

  always_comb begin
    if (pos_i < POS_W'(skip_i))          kind_o = SLOT_SKIP;
    else if (pos_i < aud_end)            kind_o = SLOT_AUDIO;
    else if (pos_i == aud_end && midi_i) kind_o = SLOT_MIDI;
    else                                 kind_o = SLOT_EXTRA;
  end
endmodule

// File: rtl/iso_rx_out.sv
module iso_rx_out
  import iso_rx_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_i,
  input  slot_e            kind_i,
  input  logic [IDX_W-1:0] chan_i,
  input  logic             label_i,
  input  logic             short_i,
  input  logic [31:0]      data_i,
  output logic             aud_valid_o,
  output logic             midi_valid_o,
  output logic [IDX_W-1:0] chan_o,
  output logic             label_o,
  output logic [31:0]      data_o,
  output logic             err_long_o,
  output logic             err_short_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aud_valid_o  <= 1'b0;
      midi_valid_o <= 1'b0;
      chan_o       <= '0;
      label_o      <= 1'b0;
      data_o       <= '0;
      err_long_o   <= 1'b0;
      err_short_o  <= 1'b0;
    end else begin
      aud_valid_o  <= beat_i && kind_i == SLOT_AUDIO;
      midi_valid_o <= beat_i && kind_i == SLOT_MIDI;
      err_long_o   <= beat_i && kind_i == SLOT_EXTRA;
      err_short_o  <= short_i;
      label_o      <= beat_i && kind_i == SLOT_AUDIO && label_i;
      if (beat_i) begin
        chan_o <= chan_i;
        data_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/iso_rx_parser.sv
module iso_rx_parser
  import iso_rx_pkg::*;
#(
  parameter  int MAX_CH = 16,
  parameter  int SKIP_W = 4,
  parameter  int ISO_W  = 6,
  localparam int CNT_W  = $clog2(MAX_CH + 1),
  localparam int IDX_W  = $clog2(MAX_CH),
  localparam int POS_W  = $clog2((2 ** SKIP_W) + MAX_CH + 1) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [ISO_W-1:0]  iso_chan_i,
  input  logic [SKIP_W-1:0] skip_i,
  input  logic [CNT_W-1:0]  aud_cnt_i,
  input  logic [3:0]        midi_ports_i,
  input  logic [MAX_CH-1:0] label_en_i,
  input  logic              in_valid_i,
  input  logic              in_sob_i,
  input  logic [ISO_W-1:0]  in_iso_i,
  input  logic [31:0]       in_data_i,
  output logic              aud_valid_o,
  output logic              midi_valid_o,
  output logic [IDX_W-1:0]  chan_o,
  output logic              label_o,
  output logic [31:0]       data_o,
  output logic              err_long_o,
  output logic              err_short_o
);
  logic              active_q;
  logic [POS_W-1:0]  pos_q, pos_eff;
  logic              iso_unused, hit_sob, hit_dat, kill, beat, short_blk;
  logic [SKIP_W-1:0] eff_skip;
  logic [CNT_W-1:0]  eff_naud, naud_q;
  logic              eff_midi, midi_q;
  logic [ISO_W-1:0]  iso_q;
  logic [POS_W-1:0]  len_q;
  slot_e             kind;
  logic [IDX_W-1:0]  chan;
  logic              label;

  assign iso_unused = &iso_chan_i;
  assign hit_sob = enable_i && in_valid_i && in_sob_i && !iso_unused && in_iso_i == iso_chan_i;
  assign kill    = enable_i && in_valid_i && in_sob_i && iso_unused;
  assign hit_dat = enable_i && in_valid_i && !in_sob_i && active_q && in_iso_i == iso_q;
  assign beat    = hit_sob || hit_dat;
  assign short_blk = hit_sob && active_q && pos_q < len_q;
  assign pos_eff = hit_sob ? '0 : pos_q;

  iso_rx_cfg #(
    .MAX_CH(MAX_CH), .SKIP_W(SKIP_W), .CNT_W(CNT_W), .ISO_W(ISO_W), .POS_W(POS_W)
  ) u_cfg (
    .clk_i, .rst_ni,
    .load_i      (hit_sob),
    .skip_i, .aud_cnt_i, .midi_ports_i,
    .iso_i       (iso_chan_i),
    .eff_skip_o  (eff_skip),
    .eff_naud_o  (eff_naud),
    .eff_midi_o  (eff_midi),
    .naud_q_o    (naud_q),
    .midi_q_o    (midi_q),
    .iso_q_o     (iso_q),
    .len_q_o     (len_q)
  );

  iso_rx_slot #(
    .SKIP_W(SKIP_W), .CNT_W(CNT_W), .POS_W(POS_W), .IDX_W(IDX_W)
  ) u_slot (
    .pos_i  (pos_eff),
    .skip_i (eff_skip),
    .naud_i (eff_naud),
    .midi_i (eff_midi),
    .kind_o (kind),
    .chan_o (chan)
  );

  // label mask is live, never captured
  assign label = (kind == SLOT_AUDIO) ? label_en_i[chan] : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      pos_q    <= '0;
    end else if (!enable_i) begin
      active_q <= 1'b0;
      pos_q    <= '0;
    end else if (hit_sob) begin
      active_q <= 1'b1;
      pos_q    <= POS_W'(1);
    end else if (kill) begin
      active_q <= 1'b0;
    end else if (hit_dat && pos_q != '1) begin
      pos_q <= pos_q + POS_W'(1);
    end
  end

  iso_rx_out #(.IDX_W(IDX_W)) u_out (
    .clk_i, .rst_ni,
    .beat_i  (beat),
    .kind_i  (kind),
    .chan_i  (chan),
    .label_i (label),
    .short_i (short_blk),
    .data_i  (in_data_i),
    .aud_valid_o, .midi_valid_o, .chan_o, .label_o, .data_o, .err_long_o, .err_short_o
  );

  a_r5_one_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({aud_valid_o, midi_valid_o, err_long_o}));

  a_r10_quiet_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !(aud_valid_o || midi_valid_o || err_long_o || err_short_o));

  a_r3_chan_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aud_valid_o |-> CNT_W'(chan_o) < naud_q);

  a_r4_midi_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    midi_valid_o |-> midi_q);

  a_r8_unused_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && in_valid_i && in_sob_i && iso_unused) |=> !active_q);

  a_r6_short_needs_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_short_o |-> $past(active_q));
endmodule

// File: tb/sim_iso_rx_parser.sv
module sim_iso_rx_parser;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CH = 4;
  localparam int SKIP_W = 2;
  localparam int ISO_W  = 6;
  localparam int CNT_W  = 3;
  localparam int IDX_W  = 2;
  localparam logic [ISO_W-1:0] STREAM = 6'd2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic enable_i = 1'b0;
  logic [ISO_W-1:0]  iso_chan_i = STREAM;
  logic [SKIP_W-1:0] skip_i = '0;
  logic [CNT_W-1:0]  aud_cnt_i = '0;
  logic [3:0]        midi_ports_i = '0;
  logic [MAX_CH-1:0] label_en_i = '0;
  logic in_valid_i = 1'b0, in_sob_i = 1'b0;
  logic [ISO_W-1:0] in_iso_i = '0;
  logic [31:0] in_data_i = '0;
  logic aud_valid_o, midi_valid_o, label_o, err_long_o, err_short_o;
  logic [IDX_W-1:0] chan_o;
  logic [31:0] data_o;

  int checks = 0, fails = 0, dn = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iso_rx_parser #(.MAX_CH(MAX_CH), .SKIP_W(SKIP_W), .ISO_W(ISO_W)) u0 (.*, .clk_i(clk));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // kind: 0 none, 1 audio, 2 midi, 3 surplus
  task automatic beat(input logic sob, input logic [ISO_W-1:0] tag, input int kind, input int ch,
                      input logic lab, input logic shrt, input string req);
    logic [31:0] d;
    logic [3:0] act, exp;
    dn++;
    d = 32'hC0DE_0000 ^ (dn * 32'h0001_0203);
    @(negedge clk);
    in_valid_i = 1'b1; in_sob_i = sob; in_iso_i = tag; in_data_i = d;
    @(posedge clk); #1;
    in_valid_i = 1'b0; in_sob_i = 1'b0;
    act = {aud_valid_o, midi_valid_o, err_long_o, err_short_o};
    exp = {kind == 1, kind == 2, kind == 3, shrt};
    chk(act == exp, req, 64'(act), 64'(exp));
    if (kind == 1)
      chk({chan_o, label_o, data_o} == {ch[IDX_W-1:0], lab, d}, req,
          64'({chan_o, label_o, data_o}), 64'({ch[IDX_W-1:0], lab, d}));
    if (kind == 2) chk(data_o == d, req, 64'(data_o), 64'(d));
  endtask

  task automatic setcfg(input int s, input int n, input int m);
    skip_i = SKIP_W'(s); aud_cnt_i = CNT_W'(n); midi_ports_i = 4'(m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int mids[3] = '{0, 1, 8};
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(posedge clk); #1;
    chk({aud_valid_o, midi_valid_o, err_long_o, err_short_o} == 4'b0, "R1",
        64'({aud_valid_o, midi_valid_o, err_long_o, err_short_o}), 64'h0);
    enable_i = 1'b1;

    // R2 R3 R4 R5 R12 sweep, label mask R9
    for (int s = 0; s < 4; s++)
      for (int n = 0; n < 8; n++)
        for (int mi = 0; mi < 3; mi++) begin
          int ne, len, m;
          m = mids[mi];
          ne = (n > MAX_CH) ? MAX_CH : n;
          len = s + ne + (m != 0 ? 1 : 0);
          setcfg(s, n, m);
          label_en_i = 4'(s * 5 + n * 3 + m);
          for (int i = 0; i < len + 2; i++) begin
            int k;
            k = (i < s) ? 0 : (i < s + ne) ? 1 : (i == s + ne && m != 0) ? 2 : 3;
            beat(i == 0, STREAM, k, i - s, (k == 1) ? label_en_i[(i - s) % MAX_CH] : 1'b0, 1'b0,
                 "R2 R3 R4 R5 R12 sweep");
          end
        end

    // R6 early block start
    setcfg(1, 3, 0);
    beat(1, STREAM, 0, 0, 0, 0, "R6");
    beat(0, STREAM, 1, 0, label_en_i[0], 0, "R6");
    label_en_i = 4'b0000;
    beat(1, STREAM, 0, 0, 0, 1, "R6 short");
    beat(0, STREAM, 1, 0, 0, 0, "R6");
    beat(0, STREAM, 1, 1, 0, 0, "R6");
    beat(0, STREAM, 1, 2, 0, 0, "R6");
    beat(0, STREAM, 3, 0, 0, 0, "R6");

    // R7 foreign iso tags
    setcfg(0, 2, 1);
    beat(1, STREAM, 1, 0, 0, 0, "R7");
    beat(0, 6'd5, 0, 0, 0, 0, "R7 foreign");
    beat(0, STREAM, 1, 1, 0, 0, "R7");
    beat(1, 6'd5, 0, 0, 0, 0, "R7 foreign start");
    beat(0, STREAM, 2, 0, 0, 0, "R7");

    // R9 live label change
    setcfg(0, 4, 0);
    beat(1, STREAM, 1, 0, 0, 0, "R9");
    beat(0, STREAM, 1, 1, 0, 0, "R9");
    label_en_i = 4'b1100;
    beat(0, STREAM, 1, 2, 1, 0, "R9");
    beat(0, STREAM, 1, 3, 1, 0, "R9");

    // R10 enable drop
    beat(1, STREAM, 1, 0, 0, 0, "R10");
    enable_i = 1'b0;
    beat(0, STREAM, 0, 0, 0, 0, "R10 off");
    beat(1, STREAM, 0, 0, 0, 0, "R10 off");
    enable_i = 1'b1;
    beat(0, STREAM, 0, 0, 0, 0, "R10 idle");
    beat(1, STREAM, 1, 0, 0, 0, "R10 restart");

    // R8 unused channel
    iso_chan_i = '1;
    beat(1, STREAM, 0, 0, 0, 0, "R8 kill");
    beat(0, STREAM, 0, 0, 0, 0, "R8");
    beat(1, 6'h3F, 0, 0, 0, 0, "R8");
    beat(0, 6'h3F, 0, 0, 0, 0, "R8");
    iso_chan_i = STREAM;

    // R11 capture at block start
    label_en_i = 4'b0000;
    setcfg(0, 3, 0);
    beat(1, STREAM, 1, 0, 0, 0, "R11");
    setcfg(2, 1, 1);
    iso_chan_i = 6'd7;
    beat(0, STREAM, 1, 1, 0, 0, "R11");
    beat(0, STREAM, 1, 2, 0, 0, "R11");
    beat(0, STREAM, 3, 0, 0, 0, "R11");
    beat(1, 6'd7, 0, 0, 0, 0, "R11 new");
    beat(0, 6'd7, 0, 0, 0, 0, "R11 new");
    beat(0, 6'd7, 1, 0, 0, 0, "R11 new");
    beat(0, 6'd7, 2, 0, 0, 0, "R11 new");
    beat(0, 6'd7, 3, 0, 0, 0, "R11 new");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule